// File: doc/BRIEF.md
# Per-Core Tick Timer Channel

This block is one tick timer channel dedicated to a single processor core. Two counters run in series. A prescale counter divides the input clock by a programmable prescale value plus one, and emits one tick per period. An interrupt counter consumes those ticks. It is loaded from a reload buffer, and when it expires it raises an interrupt flag. In periodic mode it reloads itself and keeps firing. In single-shot mode it fires once and then halts.

Software reaches the channel through a simple 32-bit register port that uses offsets within a 0x100-byte window. Writes to the prescale buffer, the reload buffer and the control register are not applied at once. Each one waits in a fixed-latency pipeline and takes effect `APPLY_LAT` clocks after the bus write. When it takes effect, a sticky acknowledge bit is set, and software clears that bit by writing 1 to it. Writes to the flag, enable and acknowledge registers act immediately. Read data is registered.

Register offsets: 0x00 prescale buffer, 0x04 prescale counter (read-only), 0x08 reload buffer, 0x0C interrupt counter (read-only), 0x20 control, 0x30 flag, 0x34 interrupt enable, 0x40 write acknowledge. The control bits are: bit 0 runs the prescaler, bit 1 runs the interrupt counter, and bit 2 selects periodic mode.

Top module: `core_tick_timer`

## Requirements
- R1: After reset all registers read zero and `irq_o` is low.
- R2: A write to offset 0x00, 0x08 or 0x20 takes effect exactly `APPLY_LAT` clocks after the bus write. In that same clock it sets acknowledge bit 0, 1 or 3 respectively of offset 0x40. Writing 1 to an acknowledge bit clears it.
- R3: A write to 0x08 changes the reload buffer only when data bit 31 is 1, and then stores the low `CNT_W` bits. The acknowledge bit is set either way.
- R4: While control bit 0 is 1, the prescale counter counts down by one per clock and reloads from the prescale buffer after reaching zero. This gives one tick every (prescale + 1) clocks.
- R5: When control bits 0 and 1 are started together from zero with prescale T and reload N≥1, flag bit 0 at 0x30 sets N·(T+1) clocks after the write applies. `irq_o` rises one clock later.
- R6: With control bit 2 set, the interrupt counter re-expires every (N+1)·(T+1) clocks.
- R7: With control bit 2 clear, the interrupt counter expires once, stops at zero and raises no further interrupt.
- R8: Writing 1 to bit 0 of 0x30 clears the flag immediately, and `irq_o` falls one clock later.
- R9: `irq_o` is high only while the flag is set and bit 0 of 0x34 was set in the previous clock.
- R10: Clearing control bit 1 freezes the interrupt counter. Clearing control bit 0 freezes the prescale counter.
- R11: A 0-to-1 transition of control bit 0 or bit 1 reloads the corresponding counter from its buffer.
- R12: `rd_data` shows the register addressed by `rd_addr` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write offset in the channel window |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read offset in the channel window |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt output |

## Verification
The bench builds the channel with `APPLY_LAT` = 4, the upper end of the apply delay, and with 16-bit counters. This keeps the arrival of each acknowledge and the first interrupt at exactly predictable clocks. Random prescale and reload values from a seeded generator cover both the divide-by-one and the divide-by-several paths, in both periodic and single-shot mode. Long reload counts with a one-clock tick make the counters visibly move, so freezing and reloading can be checked from the read-only counter offsets.

// File: rtl/ctt_pkg.sv
package ctt_pkg;
  localparam logic [7:0] OFF_PRE     = 8'h00;
  localparam logic [7:0] OFF_PRE_OBS = 8'h04;
  localparam logic [7:0] OFF_RLD     = 8'h08;
  localparam logic [7:0] OFF_CNT_OBS = 8'h0C;
  localparam logic [7:0] OFF_CTRL    = 8'h20;
  localparam logic [7:0] OFF_FLAG    = 8'h30;
  localparam logic [7:0] OFF_IEN     = 8'h34;
  localparam logic [7:0] OFF_WACK    = 8'h40;

  localparam int CTRL_PRE_RUN = 0;
  localparam int CTRL_CNT_RUN = 1;
  localparam int CTRL_PERIOD  = 2;
  localparam int RLD_LOAD_BIT = 31;

  typedef enum logic [1:0] {TGT_NONE, TGT_PRE, TGT_RLD, TGT_CTRL} tgt_e;

  typedef struct packed {
    tgt_e        tgt;
    logic [31:0] data;
  } wr_req_t;
endpackage

// File: rtl/ctt_wr_delay.sv
module ctt_wr_delay
  import ctt_pkg::*;
#(
  parameter int APPLY_LAT = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  wr_req_t req_in,
  output wr_req_t req_out
);
  wr_req_t stg [APPLY_LAT];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '{tgt: TGT_NONE, data: '0};
    else     stg[0] <= req_in;
  end

  for (genvar k = 1; k < APPLY_LAT; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[k] <= '{tgt: TGT_NONE, data: '0};
      else     stg[k] <= stg[k-1];
    end
  end

  assign req_out = stg[APPLY_LAT-1];
endmodule

// File: rtl/ctt_prescaler.sv
module ctt_prescaler #(
  parameter int PRE_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             start,
  input  logic [PRE_W-1:0] reload,
  output logic             tick,
  output logic [PRE_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (start) cnt <= reload;
    else if (run) begin
      if (cnt == '0) cnt <= reload;
      else           cnt <= cnt - PRE_W'(1);
    end
  end

  assign tick = run && !start && (cnt == '0);
endmodule

// File: rtl/ctt_irq_counter.sv
module ctt_irq_counter #(
  parameter int CNT_W = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             enable,
  input  logic             periodic,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic             expire,
  output logic             running,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (start) begin
      cnt     <= reload;
      running <= 1'b1;
    end else if (!enable) begin
      running <= 1'b0;
    end else if (tick && running) begin
      if (cnt == '0) begin
        cnt <= reload;
      end else begin
        cnt <= cnt - CNT_W'(1);
        if ((cnt == CNT_W'(1)) && !periodic) running <= 1'b0;
      end
    end
  end

  assign expire = enable && running && tick && !start && (cnt == CNT_W'(1));
endmodule

// File: rtl/core_tick_timer.sv
module core_tick_timer
  import ctt_pkg::*;
#(
  parameter int PRE_W     = 32,
  parameter int CNT_W     = 31,
  parameter int APPLY_LAT = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [7:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        irq_o
);
  localparam int ACK_W = 4;

  wr_req_t          req_in, apply_q;
  tgt_e             apply_tgt;
  logic [PRE_W-1:0] pre_buf, pre_cnt;
  logic [CNT_W-1:0] rld_buf, icnt;
  logic [2:0]       ctrl_q;
  logic             flag_q, ien_q;
  logic [ACK_W-1:0] wack_q, wack_set, wack_clr;
  logic             ap_pre, ap_rld, ap_ctrl;
  logic             pre_start, cnt_start, tick, expire, irun;
  logic             flag_clr;

  always_comb begin
    req_in.tgt  = TGT_NONE;
    req_in.data = wr_data;
    if (wr_en) begin
      case (wr_addr)
        OFF_PRE:  req_in.tgt = TGT_PRE;
        OFF_RLD:  req_in.tgt = TGT_RLD;
        OFF_CTRL: req_in.tgt = TGT_CTRL;
        default:  req_in.tgt = TGT_NONE;
      endcase
    end
  end

  ctt_wr_delay #(.APPLY_LAT(APPLY_LAT)) u_delay (
    .clk(clk), .rst(rst), .req_in(req_in), .req_out(apply_q)
  );

  assign apply_tgt = apply_q.tgt;
  assign ap_pre    = (apply_q.tgt == TGT_PRE);
  assign ap_rld    = (apply_q.tgt == TGT_RLD);
  assign ap_ctrl   = (apply_q.tgt == TGT_CTRL);
  assign pre_start = ap_ctrl && apply_q.data[CTRL_PRE_RUN] && !ctrl_q[CTRL_PRE_RUN];
  assign cnt_start = ap_ctrl && apply_q.data[CTRL_CNT_RUN] && !ctrl_q[CTRL_CNT_RUN];

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_buf <= '0;
      rld_buf <= '0;
      ctrl_q  <= '0;
    end else begin
      if (ap_pre) pre_buf <= apply_q.data[PRE_W-1:0];
      if (ap_rld && apply_q.data[RLD_LOAD_BIT]) rld_buf <= apply_q.data[CNT_W-1:0];
      if (ap_ctrl) ctrl_q <= apply_q.data[2:0];
    end
  end

  ctt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .run(ctrl_q[CTRL_PRE_RUN]), .start(pre_start),
    .reload(pre_buf), .tick(tick), .cnt(pre_cnt)
  );

  ctt_irq_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .start(cnt_start), .enable(ctrl_q[CTRL_CNT_RUN]),
    .periodic(ctrl_q[CTRL_PERIOD]), .tick(tick), .reload(rld_buf),
    .expire(expire), .running(irun), .cnt(icnt)
  );

  assign flag_clr = wr_en && (wr_addr == OFF_FLAG) && wr_data[0];
  assign wack_clr = (wr_en && (wr_addr == OFF_WACK)) ? (wr_data[ACK_W-1:0] & 4'b1011) : '0;
  assign wack_set = {ap_ctrl, 1'b0, ap_rld, ap_pre};

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ien_q  <= 1'b0;
      wack_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (expire)        flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (wr_en && (wr_addr == OFF_IEN)) ien_q <= wr_data[0];
      wack_q <= (wack_q & ~wack_clr) | wack_set;
      irq_o  <= flag_q && ien_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        OFF_PRE:     rd_data <= 32'(pre_buf);
        OFF_PRE_OBS: rd_data <= 32'(pre_cnt);
        OFF_RLD:     rd_data <= 32'(rld_buf);
        OFF_CNT_OBS: rd_data <= 32'(icnt);
        OFF_CTRL:    rd_data <= 32'(ctrl_q);
        OFF_FLAG:    rd_data <= 32'(flag_q);
        OFF_IEN:     rd_data <= 32'(ien_q);
        OFF_WACK:    rd_data <= 32'(wack_q);
        default:     rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/core_tick_timer_chk.sv
module core_tick_timer_chk
  import ctt_pkg::*;
#(
  parameter int PRE_W = 32,
  parameter int CNT_W = 31
) (
  input logic             clk,
  input logic             rst,
  input logic             irq_o,
  input logic             ien_q,
  input logic             flag_q,
  input logic             expire,
  input logic             tick,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [PRE_W-1:0] pre_buf,
  input logic [CNT_W-1:0] icnt,
  input logic [2:0]       ctrl_q,
  input logic             irun,
  input tgt_e             apply_tgt,
  input logic [3:0]       wack_q
);
  // R5
  expire_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> flag_q);

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(ien_q));

  // R7
  oneshot_halts_chk: assert property (@(posedge clk) disable iff (rst)
    (expire && !ctrl_q[CTRL_PERIOD]) |=> !irun);

  // R10
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[CTRL_CNT_RUN] && $past(!ctrl_q[CTRL_CNT_RUN])) |-> $stable(icnt));

  // R2
  ack_follows_apply_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wack_q[3]) |-> $past(apply_tgt == TGT_CTRL));

  // R4
  tick_reloads_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> (pre_cnt == $past(pre_buf)));
endmodule

bind core_tick_timer core_tick_timer_chk #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .ien_q(ien_q), .flag_q(flag_q),
  .expire(expire), .tick(tick), .pre_cnt(pre_cnt), .pre_buf(pre_buf),
  .icnt(icnt), .ctrl_q(ctrl_q), .irun(irun), .apply_tgt(apply_tgt), .wack_q(wack_q)
);

// File: tb/core_tick_timer_tb.sv
module core_tick_timer_tb;
  localparam int CLK_P = 10;
  localparam int LAT   = 4;
  localparam int PW    = 16;
  localparam int CW    = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq_o;

  int tests = 0;
  int fails = 0;
  int ncnt  = 0;
  bit done  = 1'b0;

  core_tick_timer #(.PRE_W(PW), .CNT_W(CW), .APPLY_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_o(irq_o)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) ncnt <= ncnt + 1;

  function automatic int first_lat(int t, int n);
    return LAT + n * (t + 1) + 1;
  endfunction

  function automatic int period_len(int t, int n);
    return (n + 1) * (t + 1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic wr(logic [7:0] a, logic [31:0] d, output int w);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    w = ncnt;
  endtask

  task automatic wrq(logic [7:0] a, logic [31:0] d);
    int w;
    wr(a, d, w);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wait_rise(output int e);
    int k;
    k = 0;
    while (irq_o && k < 5000) begin @(negedge clk); k++; end
    while (!irq_o && k < 5000) begin @(negedge clk); k++; end
    e = (k >= 5000) ? -1 : ncnt;
  endtask

  task automatic settle();
    repeat (LAT + 2) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    int w, e, e2;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(8'h20, v); check("R1 ctrl", v, 0);
    rd(8'h30, v); check("R1 flag", v, 0);
    rd(8'h40, v); check("R1 wack", v, 0);
    check("R1 irq", {31'b0, irq_o}, 0);

    // R2 and R12: apply latency and acknowledge timing
    rd_addr = 8'h40;
    wr(8'h00, 32'd3, w);
    repeat (LAT) @(negedge clk);
    check("R2 ack before apply", rd_data & 32'h1, 0);
    @(negedge clk);
    check("R2 ack at apply (R12 one clock later)", rd_data & 32'h1, 1);
    rd(8'h00, v); check("R2 prescale value", v, 3);
    wrq(8'h40, 32'h1); rd(8'h40, v); rd(8'h40, v);
    check("R2 ack w1c", v & 32'h1, 0);

    // R3 reload buffer gating
    wrq(8'h08, 32'h0000_0055); settle();
    rd(8'h08, v);  check("R3 no load without bit31", v, 0);
    rd(8'h40, v2); check("R3 ack still set", v2 & 32'h2, 32'h2);
    wrq(8'h08, 32'h8000_1234); settle();
    rd(8'h08, v);  check("R3 load with bit31", v, 32'h1234);
    wrq(8'h40, 32'hF);

    // R5/R6/R7 randomized rounds
    for (int r = 0; r < 6; r++) begin
      int t, n, per;
      t = $urandom_range(0, 3);
      n = $urandom_range(2, 6);
      per = r % 2;
      wrq(8'h20, 0); settle();
      wrq(8'h30, 1);
      wrq(8'h00, t);
      wrq(8'h08, 32'h8000_0000 | n);
      wrq(8'h34, 1);
      settle();
      wr(8'h20, 3 | (per << 2), w);
      wait_rise(e);
      check($sformatf("R5 first latency t=%0d n=%0d", t, n), e - w, first_lat(t, n));
      wrq(8'h30, 1);
      if (per == 1) begin
        wait_rise(e2);
        check($sformatf("R6 period t=%0d n=%0d", t, n), e2 - e, period_len(t, n));
        wrq(8'h30, 1);
      end else begin
        v2 = 0;
        for (int k = 0; k < 60; k++) begin @(negedge clk); if (irq_o) v2 = 1; end
        check("R7 no second irq", v2, 0);
        rd(8'h0C, v); check("R7 counter stopped at zero", v, 0);
      end
    end

    // R8 flag clear and irq drop
    wrq(8'h20, 0); settle();
    wrq(8'h00, 0); wrq(8'h08, 32'h8000_0002); wrq(8'h34, 1); settle();
    wrq(8'h20, 3); wait_rise(e);
    rd(8'h30, v); check("R8 flag set", v, 1);
    wrq(8'h30, 1); @(negedge clk);
    check("R8 irq dropped", {31'b0, irq_o}, 0);
    rd(8'h30, v); check("R8 flag cleared", v, 0);

    // R9 enable gating
    wrq(8'h20, 0); settle();
    wrq(8'h34, 0); wrq(8'h30, 1);
    wrq(8'h20, 3);
    v2 = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); if (irq_o) v2 = 1; end
    check("R9 irq masked", v2, 0);
    rd(8'h30, v); check("R9 flag set while masked", v, 1);
    wrq(8'h34, 1); @(negedge clk);
    check("R9 irq after enable", {31'b0, irq_o}, 1);
    wrq(8'h30, 1);

    // R4/R10/R11 interrupt counter moves, freezes, reloads
    wrq(8'h20, 0); settle();
    wrq(8'h00, 0); wrq(8'h08, 32'h8000_03E8); settle();
    wrq(8'h20, 7); settle();
    rd(8'h0C, v); repeat (4) @(negedge clk); rd(8'h0C, v2);
    check("R4 counter moves one per tick", v - v2, 5);
    wrq(8'h20, 1); settle();
    rd(8'h0C, v); repeat (6) @(negedge clk); rd(8'h0C, v2);
    check("R10 interrupt counter frozen", v2, v);
    rd_addr = 8'h0C;
    wr(8'h20, 7, w);
    repeat (LAT + 1) @(negedge clk);
    check("R11 interrupt counter reloaded", rd_data, 32'h3E8);

    // R4/R10/R11 prescale counter
    wrq(8'h20, 0); settle();
    wrq(8'h00, 200); settle();
    wrq(8'h20, 1); settle();
    rd(8'h04, v); repeat (4) @(negedge clk); rd(8'h04, v2);
    check("R4 prescaler counts down", v - v2, 5);
    wrq(8'h20, 0); settle();
    rd(8'h04, v); repeat (6) @(negedge clk); rd(8'h04, v2);
    check("R10 prescaler frozen", v2, v);
    rd_addr = 8'h04;
    wr(8'h20, 1, w);
    repeat (LAT + 1) @(negedge clk);
    check("R11 prescaler reloaded", rd_data, 200);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule